// File: doc/BRIEF.md
# Pixel Row Gate-and-Clear Sequencer

This block drives the row control of a pixel matrix in which rows are switched on and reset one at a time. Each row has two control lines: a gate line that switches the row's transistors on so that the readout can see them, and a clear line that empties the collected charge. The block walks through the rows in ascending order. In each row period it holds the gate line high for the whole period. It fires a strobe so that the readout takes the signal-plus-pedestal sample. It then pulses the row's clear line and fires a second strobe for the pedestal-only sample once the clear has ended. After that it moves on to the next row.

The rows are grouped into slices of equal size, and the slices form one chain. After the last row of one slice the active row passes to the first row of the next slice. A start pulse begins one bunch train, which is read as a fixed number of complete frames. When the last row of the last frame has finished, the block raises a one-cycle done pulse and returns to standby with every line low. It waits there until the next start. The row length, the position of the clear pulse and its width are cycle counts presented on configuration inputs. They are captured when a train starts and stay fixed until that train ends.

Top module: `pixel_row_sequencer`

## Requirements
- R1: A synchronous reset puts the block in standby. Busy, done, both strobes and every gate and clear output are low in the cycle after reset is sampled.
- R2: In standby, a start whose configuration is legal is accepted. In the next cycle busy is high and the gate of row 0 of slice 0 is high. The three configuration counts are captured at that start.
- R3: While busy, exactly one gate output is high. Each row keeps its gate high for row_len cycles. Gate bit s*ROWS+r belongs to row r of slice s, and rows follow in ascending bit order, so row ROWS-1 of slice s hands over to row 0 of slice s+1.
- R4: The signal strobe is high for one cycle in each row period, at phase clr_pos-1. The phase counts from 0 at the first cycle of the row.
- R5: The clear output of the active row, and no other clear output, is high during phases clr_pos through clr_pos+clr_len-1 of each row period.
- R6: The pedestal strobe is high for one cycle in each row period, at phase clr_pos+clr_len. This is the first cycle after the clear output has dropped.
- R7: After FRAMES passes over all SLICES*ROWS rows, busy drops and done is high for exactly one cycle. That cycle is the first cycle after the last row period. All gate and clear outputs then stay low.
- R8: A start that arrives while busy is ignored. Configuration inputs that change while busy have no effect on the running train.
- R9: A start in standby is ignored, and busy stays low, if clr_pos is 0, clr_len is 0, or clr_pos+clr_len is not less than row_len.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start of a bunch train |
| cfg_row_len | input | CW | Row period in cycles |
| cfg_clr_pos | input | CW | Phase at which the clear pulse begins |
| cfg_clr_len | input | CW | Clear pulse width in cycles |
| gate | output | SLICES*ROWS | Per-row gate enable, one-hot while busy |
| clr | output | SLICES*ROWS | Per-row clear line |
| smp_sig | output | 1 | Signal-plus-pedestal sample strobe |
| smp_ped | output | 1 | Pedestal-only sample strobe |
| busy | output | 1 | Train in progress |
| done | output | 1 | One-cycle pulse at the end of a train |

## Verification
Whole trains are run on a reduced chain of two slices of four rows and three frames. Every cycle of each train is compared against a model that derives row, phase and frame from the cycle count alone. Four timing sets are used: a minimal row with one-cycle clear, a clear placed early, a clear ending right before the last phase, and a long row. Together they separate off-by-one faults in strobe placement, in clear width and in the slice hand-off. One train also receives a second start and changed configuration part way through, which shows whether the running schedule is re-latched. Illegal timing sets and a reset in mid-train check that the block refuses to start and returns to a quiet standby.

// File: rtl/pixel_row_sequencer.sv
module pixel_row_sequencer #(
  parameter int SLICES = 2,
  parameter int ROWS   = 64,
  parameter int FRAMES = 10,
  parameter int CW     = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [CW-1:0]          cfg_row_len,
  input  logic [CW-1:0]          cfg_clr_pos,
  input  logic [CW-1:0]          cfg_clr_len,
  output logic [SLICES*ROWS-1:0] gate,
  output logic [SLICES*ROWS-1:0] clr,
  output logic                   smp_sig,
  output logic                   smp_ped,
  output logic                   busy,
  output logic                   done
);

  localparam int NR = SLICES * ROWS;
  localparam int SW = (SLICES > 1) ? $clog2(SLICES) : 1;
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int FW = (FRAMES > 1) ? $clog2(FRAMES) : 1;

  logic          run, done_q;
  logic [CW-1:0] ph, len_q, pos_q, wid_q;
  logic [SW-1:0] slc;
  logic [RW-1:0] loc;
  logic [FW-1:0] frm;

  logic [CW:0] cfg_end, ped_ph;
  logic        legal, row_end, last_loc, last_slc, last_frm, in_clr;

  assign cfg_end  = {1'b0, cfg_clr_pos} + {1'b0, cfg_clr_len};
  assign legal    = (cfg_clr_pos != '0) && (cfg_clr_len != '0) && (cfg_end < {1'b0, cfg_row_len});
  assign ped_ph   = {1'b0, pos_q} + {1'b0, wid_q};
  assign row_end  = ph == len_q - CW'(1);
  assign last_loc = loc == RW'(ROWS - 1);
  assign last_slc = slc == SW'(SLICES - 1);
  assign last_frm = frm == FW'(FRAMES - 1);
  assign in_clr   = run && (ph >= pos_q) && ({1'b0, ph} < ped_ph);

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      done_q <= 1'b0;
      ph     <= '0;
      slc    <= '0;
      loc    <= '0;
      frm    <= '0;
      len_q  <= '0;
      pos_q  <= '0;
      wid_q  <= '0;
    end else begin
      done_q <= run && row_end && last_loc && last_slc && last_frm;
      if (!run) begin
        if (start && legal) begin
          run   <= 1'b1;
          ph    <= '0;
          slc   <= '0;
          loc   <= '0;
          frm   <= '0;
          len_q <= cfg_row_len;
          pos_q <= cfg_clr_pos;
          wid_q <= cfg_clr_len;
        end
      end else if (!row_end) begin
        ph <= ph + CW'(1);
      end else begin
        ph <= '0;
        if (!last_loc) begin
          loc <= loc + RW'(1);
        end else begin
          loc <= '0;
          if (!last_slc) begin
            slc <= slc + SW'(1);
          end else begin
            slc <= '0;
            if (last_frm) run <= 1'b0;
            else          frm <= frm + FW'(1);
          end
        end
      end
    end
  end

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign gate[s*ROWS + r] = run && (slc == SW'(s)) && (loc == RW'(r));
      assign clr[s*ROWS + r]  = in_clr && (slc == SW'(s)) && (loc == RW'(r));
    end
  end

  assign smp_sig = run && (ph == pos_q - CW'(1));
  assign smp_ped = run && ({1'b0, ph} == ped_ph);
  assign busy    = run;
  assign done    = done_q;

  p_one_gate_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> $countones(gate) == 1);

  p_clr_in_row_r5: assert property (@(posedge clk) disable iff (rst)
    ($countones(clr) <= 1) && ((clr & ~gate) == '0));

  p_sig_single_r4: assert property (@(posedge clk) disable iff (rst)
    smp_sig |=> !smp_sig);

  p_sig_before_clr_r4: assert property (@(posedge clk) disable iff (rst)
    smp_sig |-> clr == '0);

  p_ped_after_clr_r6: assert property (@(posedge clk) disable iff (rst)
    smp_ped |-> (clr == '0) && ($past(clr) != '0));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (gate == '0) && (clr == '0) && !smp_sig && !smp_ped);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));

  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !row_end) |=> busy && $stable(gate));

  p_illegal_start_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && (cfg_clr_pos == '0)) |=> !busy);

endmodule

// File: tb/test_pixel_row_sequencer.sv
module test_pixel_row_sequencer;
  localparam int SL = 2, RO = 4, FR = 3, CW = 6;
  localparam int NR = SL * RO;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [CW-1:0] cfg_row_len = '0, cfg_clr_pos = '0, cfg_clr_len = '0;
  logic [NR-1:0] gate, clr;
  logic smp_sig, smp_ped, busy, done;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit finished = 1'b0;

  pixel_row_sequencer #(.SLICES(SL), .ROWS(RO), .FRAMES(FR), .CW(CW)) i_pixel_row_sequencer (
    .clk(clk), .rst(rst), .start(start),
    .cfg_row_len(cfg_row_len), .cfg_clr_pos(cfg_clr_pos), .cfg_clr_len(cfg_clr_len),
    .gate(gate), .clr(clr), .smp_sig(smp_sig), .smp_ped(smp_ped), .busy(busy), .done(done));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic quiet(input string tag);
    chk({tag, " busy"}, busy, 0);
    chk({tag, " gate"}, gate, 0);
    chk({tag, " clr"}, clr, 0);
    chk({tag, " strobes"}, {smp_sig, smp_ped}, 0);
  endtask

  task automatic train(input int L, input int S, input int W, input bit poke);
    int total;
    @(negedge clk);
    cfg_row_len = CW'(L); cfg_clr_pos = CW'(S); cfg_clr_len = CW'(W);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    total = FR * NR * L;
    for (int t = 0; t <= total + 3; t++) begin
      int idx, p;
      longint eg, ec;
      idx = t / L; p = t % L;
      if (t < total) begin
        eg = longint'(1) << (idx % NR);
        ec = (p >= S && p < S + W) ? eg : 0;
        chk(t == 0 ? "R2 first gate" : (poke ? "R8 gate" : "R3 gate"), gate, eg);
        chk("R5 clr", clr, ec);
        chk("R4 smp_sig", smp_sig, p == S - 1);
        chk("R6 smp_ped", smp_ped, p == S + W);
        chk("R7 busy", busy, 1);
        chk("R7 done", done, 0);
      end else begin
        chk("R7 done", done, t == total);
        quiet("R7 standby");
      end
      if (poke && t == 3 * L + 1) begin
        start = 1'b1; cfg_row_len = CW'(L + 3); cfg_clr_pos = CW'(1); cfg_clr_len = CW'(1);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  task automatic bad(input int L, input int S, input int W);
    @(negedge clk);
    cfg_row_len = CW'(L); cfg_clr_pos = CW'(S); cfg_clr_len = CW'(W);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      quiet("R9 illegal start");
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    quiet("R1 reset");
    chk("R1 done", done, 0);
    train(3, 1, 1, 1'b0);
    train(6, 2, 2, 1'b0);
    train(8, 3, 4, 1'b1);
    train(12, 5, 3, 1'b0);
    bad(6, 0, 2);
    bad(6, 2, 0);
    bad(6, 3, 3);
    bad(6, 4, 3);
    @(negedge clk);
    cfg_row_len = 6; cfg_clr_pos = 2; cfg_clr_len = 2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 accepted", busy, 1);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    quiet("R1 reset mid-train");
    chk("R1 done", done, 0);
    train(5, 1, 3, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule